// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial characters on a single output line. Bytes first go into a 16-entry first-in first-out buffer. The block reports how many entries the buffer holds. The serializer then sends each stored byte as one character. Each character is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. When no character is being sent, the line stays high.

The character format is chosen at run time through a set of level inputs:
- 7 or 8 data bits,
- parity on or off, and even or odd parity,
- 1 or 2 stop bits,
- 8 or 16 sampling ticks per bit.

The format is captured when a character starts, so it can change freely while a character is on the line. Bit timing comes from a sampling enable pulse supplied from outside the block. An active-low clear-to-send input gates the start of each character. A character that has already started always finishes.

Top module: `stx_top`

## Requirements
- R1: After reset, `txd` is 1, `fifo_count` is 0, `overflow` is 0 and `busy` is 0. `txd` stays 1 whenever no character is in progress.
- R2: A character goes out as bit positions in this order: a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then the stop bits of value 1.
- R3: When `fmt_len7` is 1, a character carries data bits 0 to 6 and bit 7 of the byte is not sent. When `fmt_len7` is 0, it carries bits 0 to 7.
- R4: When `fmt_par_en` is 1, a parity bit follows the data. With `fmt_par_odd` at 0, the total count of ones over the data and parity bits is even. With `fmt_par_odd` at 1, that count is odd. When `fmt_par_en` is 0, no parity bit is sent.
- R5: `fmt_stop2` at 0 sends one stop bit and at 1 sends two. After the last stop bit, `busy` drops.
- R6: Every bit lasts 16 cycles of `tick` being 1 when `fmt_os8` is 0, and 8 when it is 1. Cycles with `tick` at 0 do not advance the bit timing.
- R7: The buffer holds up to 16 bytes, and characters are sent in the order the bytes were written.
- R8: `fifo_count` equals the number of bytes written and not yet started. It rises one cycle after an accepted write and falls one cycle after a character starts.
- R9: A write while `fifo_count` is 16 is discarded and sets `overflow`. `overflow` stays 1 until reset.
- R10: A character starts only while `cts_n` is 0 and the buffer is not empty. Raising `cts_n` during a character lets that character finish but stops the next one from starting.
- R11: The format inputs are sampled only when a character starts. Changing them during a character does not alter that character's bits or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to enqueue |
| fmt_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_stop2 | input | 1 | 1: two stop bits, 0: one |
| fmt_os8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| tick | input | 1 | Sampling-clock enable |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line output |
| busy | output | 1 | A character is in progress |
| fifo_count | output | 5 | Number of stored bytes |
| overflow | output | 1 | Sticky flag for a write to a full buffer |

## Verification
A write shows up in `fifo_count` at the clock edge after the write cycle. A character starts at the edge after that, provided `cts_n` is low. The same edge drives `txd` low and lowers the count. The bench finds the first low `txd` at a falling edge and counts falling edges from there. It samples bit k at k·N + N/2 ticks, where N is 8 or 16. With `tick` held high, it checks that `busy` is still high at L·N−1 cycles and low at L·N cycles, where L is the character length in bits. A following character therefore begins one cycle after the previous stop bit ends. When `tick` is divided, only the bit centres and the final idle state are checked, because the tick phase moves the edges by up to one tick period.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int OS_LO     = 8;
    localparam int OS_HI     = 16;
    localparam int TCNT_W    = $clog2(OS_HI);

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
        logic os8;
    } fmt_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_t;

    function automatic int data_bits(input fmt_t f);
        return f.len7 ? DATA_W - 1 : DATA_W;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input fmt_t f);
        int n;
        n = 1 + data_bits(f) + (f.par_en ? 1 : 0) + (f.stop2 ? 2 : 1);
        return LEN_W'(n);
    endfunction

    function automatic logic [FRAME_MAX-1:0] frame_bits(input fmt_t f,
                                                        input logic [DATA_W-1:0] d);
        logic [FRAME_MAX-1:0] v;
        logic                 par;
        int                   nd;
        nd  = data_bits(f);
        v   = '1;
        v[0] = 1'b0;
        par = f.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                v[1 + i] = d[i];
                par      = par ^ d[i];
            end
        end
        if (f.par_en) v[1 + nd] = par;
        return v;
    endfunction

    function automatic logic [TCNT_W-1:0] last_tick(input fmt_t f);
        return f.os8 ? TCNT_W'(OS_LO - 1) : TCNT_W'(OS_HI - 1);
    endfunction

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, push;

    assign full    = (count == CNT_W'(DEPTH));
    assign push    = wr_en && !full;
    assign rd_data = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
    p_full_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> overflow);
    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $past(overflow) |-> overflow);

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  fmt_t              fmt_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tick,
    output logic              txd,
    output logic              busy
);
    ser_state_t           state;
    fmt_t                 fmt_q;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     bits_left;
    logic [TCNT_W-1:0]    tcnt;
    logic                 bit_end;

    assign busy    = (state == SER_SEND);
    assign txd     = shreg[0];
    assign bit_end = tick && (tcnt == last_tick(fmt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SER_IDLE;
            fmt_q     <= '0;
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (start) begin
                        fmt_q     <= fmt_in;
                        shreg     <= frame_bits(fmt_in, data_in);
                        bits_left <= frame_len(fmt_in);
                        tcnt      <= '0;
                        state     <= SER_SEND;
                    end
                end
                SER_SEND: begin
                    if (bit_end) begin
                        tcnt      <= '0;
                        shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == LEN_W'(1)) state <= SER_IDLE;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);
    p_fmt_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fmt_q));
    p_last_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(txd));

endmodule

// File: rtl/stx_top.sv
module stx_top
    import stx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_data,
    input  logic                       fmt_len7,
    input  logic                       fmt_par_en,
    input  logic                       fmt_par_odd,
    input  logic                       fmt_stop2,
    input  logic                       fmt_os8,
    input  logic                       tick,
    input  logic                       cts_n,
    output logic                       txd,
    output logic                       busy,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    fmt_t              fmt_live;
    logic [DATA_W-1:0] head;
    logic              start;

    assign fmt_live = '{len7: fmt_len7, par_en: fmt_par_en, par_odd: fmt_par_odd,
                        stop2: fmt_stop2, os8: fmt_os8};
    assign start    = !busy && (fifo_count != CNT_W'(0)) && !cts_n;

    stx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (start),
        .rd_data  (head),
        .count    (fifo_count),
        .overflow (overflow)
    );

    stx_serializer u_ser (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fmt_in  (fmt_live),
        .data_in (head),
        .tick    (tick),
        .txd     (txd),
        .busy    (busy)
    );

    p_cts_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!cts_n));
    p_start_pops_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(wr_en)) |-> (fifo_count == $past(fifo_count) - 1'b1));

endmodule

// File: tb/stx_top_bench.sv
module stx_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       c_len7 = 1'b0, c_par_en = 1'b0, c_par_odd = 1'b0, c_stop2 = 1'b0, c_os8 = 1'b1;
    logic       tick = 1'b1;
    logic       cts_n = 1'b1;
    logic       txd, busy, overflow;
    logic [4:0] fifo_count;

    int checks = 0;
    int failures = 0;
    int tdiv = 1;
    int cur = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stx_top u_stx_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fmt_len7(c_len7), .fmt_par_en(c_par_en), .fmt_par_odd(c_par_odd),
        .fmt_stop2(c_stop2), .fmt_os8(c_os8), .tick(tick), .cts_n(cts_n),
        .txd(txd), .busy(busy), .fifo_count(fifo_count), .overflow(overflow)
    );

    initial begin : tick_gen
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            if (ph >= tdiv) ph = 0;
            tick = (ph == 0);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic goto(input int off);
        while (cur < off) begin
            @(negedge clk);
            cur++;
        end
    endtask

    task automatic check_frame(input logic [7:0] b, input bit disturb, input string tag);
        int   nd, n, len, ones, guard;
        logic ev [12];
        string role;
        bit   l7, pe, po, s2, o8;
        l7 = c_len7; pe = c_par_en; po = c_par_odd; s2 = c_stop2; o8 = c_os8;
        nd = l7 ? 7 : 8;
        n  = o8 ? 8 : 16;
        ones = 0;
        for (int i = 0; i < 12; i++) ev[i] = 1'b1;
        ev[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            ev[1 + i] = b[i];
            ones += int'(b[i]);
        end
        if (pe) ev[1 + nd] = ((ones % 2) == 1) ^ po;
        len = 1 + nd + (pe ? 1 : 0) + (s2 ? 2 : 1);
        guard = 0;
        while (txd !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " start found"}, int'(guard < 20000), 1);
        cur = 0;
        for (int k = 0; k < len; k++) begin
            goto((k * n + n / 2) * tdiv);
            if (k == 0)                   role = "R2 start bit";
            else if (k <= nd)             role = "R3 data bit";
            else if (pe && k == nd + 1)   role = "R4 parity bit";
            else                          role = "R5 stop bit";
            check(role, int'(txd), int'(ev[k]));
            if (k == 0 && disturb) begin
                c_len7 = ~l7; c_par_en = ~pe; c_par_odd = ~po;
                c_stop2 = ~s2; c_os8 = ~o8; cts_n = 1'b1;
            end
        end
        if (tdiv == 1) begin
            goto(len * n - 1);
            check({tag, " busy until last tick"}, int'(busy), 1);
        end
        goto(len * n * tdiv);
        check({tag, " busy clear after frame"}, int'(busy), 0);
        check("R1 line high after frame", int'(txd), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txd after reset", int'(txd), 1);
        check("R1 count after reset", int'(fifo_count), 0);
        check("R1 overflow after reset", int'(overflow), 0);
        check("R1 busy after reset", int'(busy), 0);

        // R2..R6 sweep over every format, tick held high
        cts_n = 1'b0;
        for (int idx = 0; idx < 32; idx++) begin
            c_len7 = idx[0]; c_par_en = idx[1]; c_par_odd = idx[2];
            c_stop2 = idx[3]; c_os8 = idx[4];
            write_byte(8'(8'hA5 ^ (idx * 37)));
            check_frame(8'(8'hA5 ^ (idx * 37)), 1'b0, "R6");
        end

        // R6 tick gating: divided sampling enable
        tdiv = 3;
        for (int idx = 0; idx < 4; idx++) begin
            c_len7 = idx[0]; c_par_en = 1'b1; c_par_odd = idx[1];
            c_stop2 = idx[0]; c_os8 = idx[1];
            write_byte(8'(8'h3C + idx * 51));
            check_frame(8'(8'h3C + idx * 51), 1'b0, "R6 divided tick");
        end
        tdiv = 1;
        repeat (4) @(negedge clk);

        // R7 R8 R9 fill, overflow, drain order
        c_len7 = 1'b0; c_par_en = 1'b0; c_par_odd = 1'b0; c_stop2 = 1'b0; c_os8 = 1'b1;
        cts_n = 1'b1;
        for (int i = 0; i < 17; i++) begin
            write_byte(8'(8'h40 + i * 7));
            check("R8 count after write", int'(fifo_count), (i + 1 > 16) ? 16 : i + 1);
            check("R9 overflow flag", int'(overflow), (i == 16) ? 1 : 0);
        end
        check("R10 no start while cts high", int'(busy), 0);
        cts_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            check_frame(8'(8'h40 + i * 7), 1'b0, "R7");
            check("R8 count after start", int'(fifo_count), 15 - i);
        end
        repeat (200) @(negedge clk);
        check("R9 discarded byte never sent", int'(busy), 0);
        check("R9 overflow sticky", int'(overflow), 1);
        check("R8 count drained", int'(fifo_count), 0);
        check("R1 idle line", int'(txd), 1);

        // R10 R11 flow control and config capture
        cts_n = 1'b1;
        write_byte(8'h5A);
        write_byte(8'hC3);
        repeat (40) @(negedge clk);
        check("R10 held by cts", int'(busy), 0);
        check("R10 count while held", int'(fifo_count), 2);
        check("R10 line idle while held", int'(txd), 1);
        cts_n = 1'b0;
        check_frame(8'h5A, 1'b1, "R11");
        repeat (60) @(negedge clk);
        check("R10 next held after cts raised", int'(busy), 0);
        check("R10 count after held", int'(fifo_count), 1);
        c_len7 = 1'b0; c_par_en = 1'b0; c_par_odd = 1'b0; c_stop2 = 1'b0; c_os8 = 1'b1;
        cts_n = 1'b0;
        check_frame(8'hC3, 1'b0, "R10");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule